// File: doc/BRIEF.md
# In-Order Memory Operation Queue with Store-to-Load Forwarding

This block holds every in-flight load and store of an out-of-order core in a circular buffer, oldest at the head and youngest at the tail. Operations enter at dispatch with no address. The address-calculation path later writes each effective address, and for stores the store data as well, into the slot that dispatch reported. The queue only performs the memory access. It does not compute addresses.

Each cycle the queue looks for the oldest load that has an address, has not yet been issued, and has no older store with an unknown address ahead of it. If the youngest older store with a known address has the same full word address, that store's data goes straight back to the core on the forward port and memory is not touched. If not, the load is offered to memory. A store writes memory only when the core commits it at the head. On a misprediction the core hands back the tail pointer value it recorded when the branch was dispatched, and every entry from that point onward is dropped.

Dispatch and the memory load request use valid/ready. A dispatch is taken on a cycle with both `disp_valid` and `disp_ready` high. `disp_ready` is low while the queue is full or a flush is present. A load request transfers on a cycle with both `ld_valid` and `ld_ready` high. While `ld_ready` is low the offered request stays unless an address write makes an older load ready, and in that case the older load is offered in its place. The store write is qualified by `st_valid`/`st_ready` and is tied to the commit handshake.

Top module: `lsq_top`

## Requirements
- R1: After reset the queue is empty. `disp_ready`=1, `disp_ptr`=0, and `ld_valid`, `fwd_valid`, `commit_ready` and `st_valid` are all 0.
- R2: `disp_ptr` is the tail pointer. Its MSB is the wrap bit and its low bits are the slot index. Each accepted dispatch increments it by 1.
- R3: With DEPTH entries in the queue, `disp_ready`=0, and a `disp_valid` pulse changes nothing (`disp_ptr` holds).
- R4: A load with an address and no older store is offered with its slot and address on `ld_valid` one cycle after the address write. It stays offered while `ld_ready`=0 and is dropped after the cycle with `ld_valid`&&`ld_ready`.
- R5: A load with an address is neither offered nor forwarded while any older store in the queue lacks an address, whatever address that store later gets.
- R6: When the youngest older store with an address has the same full address as the load, `fwd_valid`=1 with that store's data and the load's slot, `ld_valid` is 0, and no memory request is ever made for that load.
- R7: A store younger than a load never forwards to it. Such a load goes to memory.
- R8: At most one load is chosen per cycle. When several are ready, the one nearest the head is chosen.
- R9: `st_valid` is high only while `commit_valid`=1 and the head is a store with an address. It carries the head's address and data, and the head entry is freed on the cycle with `st_ready`.
- R10: For a load at the head, `commit_ready`=1 only once that load has been issued or forwarded.
- R11: `flush_valid` sets the tail to `flush_ptr`. Entries from `flush_ptr` onward are discarded and never issue, and the next dispatch uses `flush_ptr`.
- R12: During a flush cycle `disp_ready`=0, and a dispatch offered in that cycle is not taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| disp_valid | input | 1 | Dispatch offer |
| disp_ready | output | 1 | Dispatch can be taken |
| disp_is_store | input | 1 | 1 = store, 0 = load |
| disp_ptr | output | PTRW | Tail pointer: wrap bit and slot given to the next dispatch |
| agen_valid | input | 1 | Effective address write |
| agen_slot | input | IDXW | Slot being written |
| agen_addr | input | AW | Full word address |
| agen_data | input | DW | Store data (ignored for loads) |
| ld_valid | output | 1 | Load request to memory |
| ld_ready | input | 1 | Memory takes the load request |
| ld_addr | output | AW | Load address |
| ld_slot | output | IDXW | Slot of the offered load |
| fwd_valid | output | 1 | Load result forwarded from a store |
| fwd_slot | output | IDXW | Slot of the forwarded load |
| fwd_data | output | DW | Forwarded data |
| commit_valid | input | 1 | Core commits the head operation |
| commit_ready | output | 1 | Head can retire this cycle |
| st_valid | output | 1 | Store write to memory |
| st_ready | input | 1 | Memory takes the store write |
| st_addr | output | AW | Store address |
| st_data | output | DW | Store data |
| flush_valid | input | 1 | Misprediction flush |
| flush_ptr | input | PTRW | Tail value recorded when the branch was dispatched |

## Verification
Dispatch, address writes and flushes change state at one clock edge, and their effect shows on `disp_ptr`, `ld_valid` or `fwd_valid` just after that edge, with no added pipeline register. The request or forward that an address write makes possible therefore belongs to the cycle right after that write. `commit_ready` and `st_valid` follow the current inputs in the same cycle. Inputs change at the falling edge, and every check samples one time unit later or just before the next rising edge. A monitor compares each memory transfer and forward, in order, with the queue of events the driver predicted, so a missing, extra or reordered access is reported.

// File: rtl/lsq_pkg.sv
package lsq_pkg;
  typedef struct packed {
    logic is_store;
    logic addr_ok;
    logic issued;
  } lsq_flags_t;
endpackage

// File: rtl/lsq_ptrs.sv
module lsq_ptrs #(
  parameter int DEPTH = 8,
  localparam int IDXW = $clog2(DEPTH),
  localparam int PTRW = IDXW + 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            push,
  input  logic            pop,
  input  logic            flush,
  input  logic [PTRW-1:0] flush_ptr,
  output logic [PTRW-1:0] head,
  output logic [PTRW-1:0] tail,
  output logic [PTRW-1:0] occ,
  output logic            full,
  output logic            empty
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head <= '0;
      tail <= '0;
    end else begin
      if (pop) head <= head + 1'b1;
      if (flush)     tail <= flush_ptr;
      else if (push) tail <= tail + 1'b1;
    end
  end

  assign occ   = tail - head;
  assign full  = (occ == PTRW'(DEPTH));
  assign empty = (occ == '0);
endmodule

// File: rtl/lsq_select.sv
module lsq_select
  import lsq_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int AW    = 32,
  parameter int DW    = 32,
  localparam int IDXW = $clog2(DEPTH),
  localparam int PTRW = IDXW + 1
) (
  input  logic [IDXW-1:0] head_idx,
  input  logic [PTRW-1:0] occ,
  input  lsq_flags_t      flags    [DEPTH],
  input  logic [AW-1:0]   addr_arr [DEPTH],
  input  logic [DW-1:0]   data_arr [DEPTH],
  output logic            pick_valid,
  output logic [IDXW-1:0] pick_idx,
  output logic            fwd_hit,
  output logic [DW-1:0]   fwd_data
);
  // Walk entries oldest first; an unresolved store blocks every younger load.
  always_comb begin
    logic            blk;
    logic [IDXW-1:0] ix;
    logic [IDXW-1:0] pick_age;
    blk        = 1'b0;
    ix         = '0;
    pick_age   = '0;
    pick_valid = 1'b0;
    pick_idx   = '0;
    fwd_hit    = 1'b0;
    fwd_data   = '0;
    for (int k = 0; k < DEPTH; k++) begin
      ix = head_idx + IDXW'(k);
      if (PTRW'(k) < occ) begin
        if (flags[ix].is_store) begin
          if (!flags[ix].addr_ok) blk = 1'b1;
        end else if (flags[ix].addr_ok && !flags[ix].issued && !blk && !pick_valid) begin
          pick_valid = 1'b1;
          pick_idx   = ix;
          pick_age   = IDXW'(k);
        end
      end
    end
    // Youngest older store with the same address wins (later hit overwrites).
    for (int m = 0; m < DEPTH; m++) begin
      ix = head_idx + IDXW'(m);
      if (pick_valid && IDXW'(m) < pick_age && flags[ix].is_store &&
          flags[ix].addr_ok && addr_arr[ix] == addr_arr[pick_idx]) begin
        fwd_hit  = 1'b1;
        fwd_data = data_arr[ix];
      end
    end
  end
endmodule

// File: rtl/lsq_top.sv
module lsq_top
  import lsq_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int AW    = 32,
  parameter int DW    = 32,
  localparam int IDXW = $clog2(DEPTH),
  localparam int PTRW = IDXW + 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            disp_valid,
  output logic            disp_ready,
  input  logic            disp_is_store,
  output logic [PTRW-1:0] disp_ptr,
  input  logic            agen_valid,
  input  logic [IDXW-1:0] agen_slot,
  input  logic [AW-1:0]   agen_addr,
  input  logic [DW-1:0]   agen_data,
  output logic            ld_valid,
  input  logic            ld_ready,
  output logic [AW-1:0]   ld_addr,
  output logic [IDXW-1:0] ld_slot,
  output logic            fwd_valid,
  output logic [IDXW-1:0] fwd_slot,
  output logic [DW-1:0]   fwd_data,
  input  logic            commit_valid,
  output logic            commit_ready,
  output logic            st_valid,
  input  logic            st_ready,
  output logic [AW-1:0]   st_addr,
  output logic [DW-1:0]   st_data,
  input  logic            flush_valid,
  input  logic [PTRW-1:0] flush_ptr
);
  lsq_flags_t      flags_q [DEPTH];
  logic [AW-1:0]   addr_q  [DEPTH];
  logic [DW-1:0]   data_q  [DEPTH];
  logic [PTRW-1:0] head, tail, occ;
  logic            full, empty, push, pop;
  logic            pick_valid, fwd_hit, mark_issue;
  logic [IDXW-1:0] pick_idx, head_idx, tail_idx;
  logic [DW-1:0]   sel_data;
  lsq_flags_t      hf;

  assign head_idx   = head[IDXW-1:0];
  assign tail_idx   = tail[IDXW-1:0];
  assign disp_ready = !full && !flush_valid;
  assign push       = disp_valid && disp_ready;
  assign disp_ptr   = tail;

  lsq_ptrs #(.DEPTH(DEPTH)) ptrs_i (
    .clk(clk), .rst_n(rst_n), .push(push), .pop(pop),
    .flush(flush_valid), .flush_ptr(flush_ptr),
    .head(head), .tail(tail), .occ(occ), .full(full), .empty(empty)
  );

  lsq_select #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) sel_i (
    .head_idx(head_idx), .occ(occ), .flags(flags_q), .addr_arr(addr_q),
    .data_arr(data_q), .pick_valid(pick_valid), .pick_idx(pick_idx),
    .fwd_hit(fwd_hit), .fwd_data(sel_data)
  );

  // Issue side
  assign ld_valid   = pick_valid && !fwd_hit;
  assign ld_slot    = pick_idx;
  assign ld_addr    = addr_q[pick_idx];
  assign fwd_valid  = pick_valid && fwd_hit;
  assign fwd_slot   = pick_idx;
  assign fwd_data   = sel_data;
  assign mark_issue = fwd_valid || (ld_valid && ld_ready);

  // Commit side
  assign hf           = flags_q[head_idx];
  assign st_valid     = commit_valid && !empty && hf.is_store && hf.addr_ok;
  assign st_addr      = addr_q[head_idx];
  assign st_data      = data_q[head_idx];
  assign commit_ready = !empty && (hf.is_store ? (hf.addr_ok && st_ready) : hf.issued);
  assign pop          = commit_valid && commit_ready;

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (!rst_n) begin
        flags_q[i] <= '0;
      end else if (push && tail_idx == IDXW'(i)) begin
        flags_q[i] <= '{is_store: disp_is_store, addr_ok: 1'b0, issued: 1'b0};
      end else begin
        if (agen_valid && agen_slot == IDXW'(i)) flags_q[i].addr_ok <= 1'b1;
        if (mark_issue && pick_idx == IDXW'(i))  flags_q[i].issued  <= 1'b1;
      end
      if (agen_valid && agen_slot == IDXW'(i)) begin
        addr_q[i] <= agen_addr;
        data_q[i] <= agen_data;
      end
    end
  end
endmodule

// File: rtl/lsq_chk.sv
module lsq_chk #(
  parameter int DEPTH = 8,
  parameter int IDXW  = 3,
  parameter int PTRW  = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            disp_valid,
  input logic            disp_ready,
  input logic [PTRW-1:0] disp_ptr,
  input logic [PTRW-1:0] occ,
  input logic            flush_valid,
  input logic [PTRW-1:0] flush_ptr,
  input logic            agen_valid,
  input logic            ld_valid,
  input logic            ld_ready,
  input logic [IDXW-1:0] ld_slot,
  input logic            fwd_valid,
  input logic            st_valid,
  input logic            commit_valid
);
  a_r2_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
    disp_valid && disp_ready |=> disp_ptr == $past(disp_ptr) + 1'b1);

  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= PTRW'(DEPTH));

  a_r3_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
    disp_valid && !disp_ready && !flush_valid |=> $stable(disp_ptr));

  a_r4_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    ld_valid && !ld_ready && !flush_valid && !agen_valid |=> ld_valid && $stable(ld_slot));

  a_r6_fwd_no_mem: assert property (@(posedge clk) disable iff (!rst_n)
    !(fwd_valid && ld_valid));

  a_r9_store_on_commit: assert property (@(posedge clk) disable iff (!rst_n)
    st_valid |-> commit_valid);

  a_r11_flush_tail: assert property (@(posedge clk) disable iff (!rst_n)
    flush_valid |=> disp_ptr == $past(flush_ptr));
endmodule

bind lsq_top lsq_chk #(.DEPTH(DEPTH), .IDXW(IDXW), .PTRW(PTRW)) chk_i (
  .clk(clk), .rst_n(rst_n), .disp_valid(disp_valid), .disp_ready(disp_ready),
  .disp_ptr(disp_ptr), .occ(occ), .flush_valid(flush_valid), .flush_ptr(flush_ptr),
  .agen_valid(agen_valid), .ld_valid(ld_valid), .ld_ready(ld_ready),
  .ld_slot(ld_slot), .fwd_valid(fwd_valid), .st_valid(st_valid),
  .commit_valid(commit_valid)
);

// File: tb/lsq_top_tb_top.sv
`timescale 1ns/1ps
module lsq_top_tb_top;
  localparam int DEPTH = 8;
  localparam int AW = 32;
  localparam int DW = 32;
  localparam int IDXW = 3;
  localparam int PTRW = 4;

  logic clk = 0, rst_n = 0;
  logic disp_valid = 0, disp_is_store = 0, disp_ready;
  logic [PTRW-1:0] disp_ptr;
  logic agen_valid = 0;
  logic [IDXW-1:0] agen_slot = 0;
  logic [AW-1:0] agen_addr = 0;
  logic [DW-1:0] agen_data = 0;
  logic ld_valid, ld_ready = 0;
  logic [AW-1:0] ld_addr;
  logic [IDXW-1:0] ld_slot, fwd_slot;
  logic fwd_valid;
  logic [DW-1:0] fwd_data;
  logic commit_valid = 0, commit_ready;
  logic st_valid, st_ready = 1;
  logic [AW-1:0] st_addr;
  logic [DW-1:0] st_data;
  logic flush_valid = 0;
  logic [PTRW-1:0] flush_ptr = 0;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  typedef struct {
    int kind;            // 0 memory load, 1 forward, 2 store write
    int slot;
    logic [AW-1:0] a;
    logic [DW-1:0] d;
    string req;
  } ev_t;
  ev_t exp_q[$];

  always #5 clk = ~clk;

  lsq_top #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) dut_i (.*);

  task automatic check(input bit ok, input string req, input longint act, input longint expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic expect_ev(input int kind, input int slot, input logic [AW-1:0] a,
                           input logic [DW-1:0] d, input string req);
    ev_t e;
    e.kind = kind; e.slot = slot; e.a = a; e.d = d; e.req = req;
    exp_q.push_back(e);
  endtask

  // Monitor: sample just before each rising edge
  always begin
    @(negedge clk);
    #4;
    if (rst_n) begin
      ev_t g;
      bit seen;
      seen = 0;
      if (ld_valid && ld_ready) begin
        g.kind = 0; g.slot = int'(ld_slot); g.a = ld_addr; g.d = '0; seen = 1;
      end
      if (fwd_valid) begin
        g.kind = 1; g.slot = int'(fwd_slot); g.a = '0; g.d = fwd_data; seen = 1;
      end
      if (st_valid && st_ready) begin
        g.kind = 2; g.slot = -1; g.a = st_addr; g.d = st_data; seen = 1;
      end
      if (seen) begin
        if (exp_q.size() == 0) begin
          check(0, "unexpected event", g.kind, -1);
        end else begin
          ev_t e;
          e = exp_q.pop_front();
          if (e.kind == 2) g.slot = e.slot;
          check(g.kind == e.kind && g.slot == e.slot && g.a == e.a && g.d == e.d,
                e.req, {g.kind[3:0], g.slot[3:0], g.a[23:0], g.d[31:0]},
                {e.kind[3:0], e.slot[3:0], e.a[23:0], e.d[31:0]});
        end
      end
    end
  end

  task automatic tick(); @(negedge clk); endtask

  task automatic disp(input bit st);
    disp_is_store = st; disp_valid = 1; tick(); disp_valid = 0;
  endtask

  task automatic agen(input int slot, input logic [AW-1:0] a, input logic [DW-1:0] d);
    agen_slot = IDXW'(slot); agen_addr = a; agen_data = d; agen_valid = 1;
    tick(); agen_valid = 0;
  endtask

  task automatic commit_n(input int n);
    commit_valid = 1;
    for (int i = 0; i < n; i++) begin
      #1 check(commit_ready == 1, "R9/R10 commit ready", commit_ready, 1);
      tick();
    end
    commit_valid = 0;
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      check(0, "watchdog", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    rst_n = 1;
    tick();
    #1;
    // R1 reset state
    check(disp_ready == 1, "R1 disp_ready", disp_ready, 1);
    check(disp_ptr == 0, "R1 disp_ptr", disp_ptr, 0);
    check(!ld_valid && !fwd_valid, "R1 issue idle", {ld_valid, fwd_valid}, 0);
    check(!commit_ready && !st_valid, "R1 commit idle", {commit_ready, st_valid}, 0);

    // Single load to memory, held under back-pressure (R2, R4, R10)
    disp(0);
    #1 check(disp_ptr == 1, "R2 ptr step", disp_ptr, 1);
    agen(0, 'h100, 0);
    #1 check(ld_valid && ld_slot == 0 && ld_addr == 'h100, "R4 offer", {ld_valid, ld_slot, ld_addr}, 'h100 | (64'h1 << 35));
    check(commit_ready == 0, "R10 not issued", commit_ready, 0);
    tick();
    #1 check(ld_valid == 1, "R4 held", ld_valid, 1);
    expect_ev(0, 0, 'h100, 0, "R4 load");
    ld_ready = 1;
    tick();
    ld_ready = 0;
    #1 check(ld_valid == 0, "R4 once", ld_valid, 0);
    check(commit_ready == 1, "R10 issued", commit_ready, 1);
    tick();
    commit_n(1);

    // Blocking and forwarding (R5, R6, R9); slots 1,2 stores, 3 load
    disp(1); disp(1); disp(0);
    agen(3, 'h200, 0);
    #1 check(!ld_valid && !fwd_valid, "R5 blocked both", {ld_valid, fwd_valid}, 0);
    tick();
    agen(2, 'h200, 'hB2);
    #1 check(!ld_valid && !fwd_valid, "R5 blocked oldest", {ld_valid, fwd_valid}, 0);
    check(st_valid == 0, "R9 no write before commit", st_valid, 0);
    tick();
    expect_ev(1, 3, 0, 'hB2, "R6 forward youngest");
    ld_ready = 1;
    agen(1, 'h200, 'hB1);
    #1 check(fwd_valid && fwd_data == 'hB2 && !ld_valid, "R6 forward data", fwd_data, 'hB2);
    tick();
    ld_ready = 0;
    expect_ev(2, -1, 'h200, 'hB1, "R9 store 1");
    expect_ev(2, -1, 'h200, 'hB2, "R9 store 2");
    commit_n(3);

    // Younger store and oldest-first choice (R7, R8); slots 4 L, 5 S, 6 L
    disp(0); disp(1); disp(0);
    agen(5, 'h300, 'hC5);
    agen(6, 'h340, 0);
    #1 check(ld_valid && ld_slot == 6, "R8 only ready", ld_slot, 6);
    tick();
    agen(4, 'h300, 0);
    #1 check(ld_valid && ld_slot == 4, "R8 oldest", ld_slot, 4);
    check(fwd_valid == 0, "R7 no younger forward", fwd_valid, 0);
    expect_ev(0, 4, 'h300, 0, "R7 load to memory");
    expect_ev(0, 6, 'h340, 0, "R8 second load");
    ld_ready = 1;
    tick(); tick();
    ld_ready = 0;
    #1 check(ld_valid == 0, "R8 one per cycle", ld_valid, 0);
    tick();
    expect_ev(2, -1, 'h300, 'hC5, "R9 store 5");
    commit_n(3);

    // Fill, overflow attempt, flush (R3, R11, R12); slots 7,0..6
    for (int i = 0; i < DEPTH; i++) disp(0);
    #1 check(disp_ready == 0, "R3 full", disp_ready, 0);
    check(disp_ptr == 15, "R3 ptr", disp_ptr, 15);
    tick();
    disp(0);
    #1 check(disp_ptr == 15, "R3 ignored", disp_ptr, 15);
    tick();
    flush_ptr = 10; flush_valid = 1;
    tick();
    flush_valid = 0;
    #1 check(disp_ptr == 10, "R11 tail", disp_ptr, 10);
    check(disp_ready == 1, "R11 space", disp_ready, 1);
    tick();
    flush_valid = 1; disp_valid = 1; disp_is_store = 0;
    #1 check(disp_ready == 0, "R12 ready low", disp_ready, 0);
    tick();
    flush_valid = 0; disp_valid = 0;
    #1 check(disp_ptr == 10, "R12 not taken", disp_ptr, 10);
    tick();
    ld_ready = 1;
    agen(3, 'h3A0, 0);
    #1 check(!ld_valid && !fwd_valid, "R11 discarded", {ld_valid, fwd_valid}, 0);
    tick();
    #1 check(!ld_valid, "R11 discarded later", ld_valid, 0);
    tick();
    expect_ev(0, 7, 'h400, 0, "R11 kept 7");
    expect_ev(0, 0, 'h410, 0, "R11 kept 0");
    expect_ev(0, 1, 'h420, 0, "R11 kept 1");
    agen(7, 'h400, 0);
    agen(0, 'h410, 0);
    agen(1, 'h420, 0);
    tick();
    ld_ready = 0;
    commit_n(3);
    disp(0);
    #1 check(disp_ptr == 11, "R11 reuse", disp_ptr, 11);
    check(exp_q.size() == 0, "all events seen", exp_q.size(), 0);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule